// File: doc/BRIEF.md
# Port Direction Control with Split Reset Classes

This block holds the input/output direction of a 32-pin general-purpose port. The direction bits live in two 16-bit registers: one covers the upper pins 31..16 and one covers the lower pins 15..0. Within each half, bit n belongs to pin n of that half. Software reads and writes both registers over a small register bus. One select line picks the half. A write strobe commits the write data on the next clock edge. Read data follows the selected half without a clock delay.

For each pin, the stored direction bit is combined with a function-select flag. When the flag marks the pin as general-purpose I/O, the pin is driven exactly when its direction bit is 1. When the flag marks another function, the direction bit is ignored. The output-enable of that other function is passed straight through instead.

Two kinds of reset reach the block, and they act differently:

- A power-on reset, or entry into deep standby, clears both registers.
- A manual reset, or entry into sleep or software standby, leaves the registers holding their values.

Top module: `gpiodir_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both registers clear to 0x0000.
- R2: With `bus_we`=1 and `bus_sel_hi`=1 at an edge, the upper register (pins 31..16) takes `bus_wdata` and the lower register is unchanged.
- R3: With `bus_we`=1 and `bus_sel_hi`=0 at an edge, the lower register (pins 15..0) takes `bus_wdata` and the upper register is unchanged.
- R4: `bus_rdata` shows the upper register when `bus_sel_hi`=1 and the lower register when it is 0, in the same cycle with no clock delay.
- R5: A clear request (`rst_n` low or `dstby_enter` high) wins over a write in the same cycle, so the register ends at 0x0000.
- R6: `dstby_enter`=1 at an edge clears both registers.
- R7: Holding `mrst_n` low has no effect on either register.
- R8: `lp_enter`=1 (sleep or software standby entry) has no effect on either register.
- R9: For a pin with `pin_gpio[i]`=1, `pin_oe[i]` equals its direction bit, where 1 means output and 0 means input.
- R10: For a pin with `pin_gpio[i]`=0, `pin_oe[i]` equals `alt_oe[i]` and the direction bit is ignored.
- R11: Register reads return the last value written, whatever the state of `pin_gpio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous; clears both registers |
| dstby_enter | input | 1 | Deep standby entry; clears both registers |
| mrst_n | input | 1 | Manual reset, active low; registers keep their values |
| lp_enter | input | 1 | Sleep or software standby entry; registers keep their values |
| bus_sel_hi | input | 1 | Register select: 1 = upper half, 0 = lower half |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data from the selected half |
| pin_gpio | input | 32 | Per pin, 1 = general-purpose I/O function selected |
| alt_oe | input | 32 | Output-enable from the alternate function, per pin |
| pin_oe | output | 32 | Output-enable delivered to each pin |

## Verification
The block has two kinds of result with different timing:

- **Register-state results** (writes and clears) are due one rising edge after the stimulus.
- **Combinational results** (`bus_rdata` and `pin_oe`) are due in the same cycle the inputs change.

The driver applies every stimulus on a falling edge. A write is held across exactly one rising edge. The monitor compares each queued expectation two nanoseconds after the falling edge on which it was pushed. By then a write from the preceding rising edge has landed, and the combinational paths have settled. The checks that reset inputs have no effect read both halves back after the pulse ends and before any further write.

// File: rtl/gpiodir_pkg.sv
// Package: shared sizing constants for the port direction block.
// Assumes the port splits into two equal halves.
package gpiodir_pkg;
    localparam int PIN_COUNT = 32;
    localparam int HALF_W    = PIN_COUNT / 2;
endpackage

// File: rtl/gpiodir_half_reg.sv
// Module: one half of the direction storage.
// Clears synchronously when clr is high; a clear outranks a write.
// Otherwise loads wdata when we is high, and holds in every other case.
// Assumes clr already merges the power-on and deep-standby requests.
module gpiodir_half_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Purpose: storage with clear priority over load.
    always_ff @(posedge clk) begin
        if (clr)     q <= '0;
        else if (we) q <= wdata;
    end

    // R6: an active clear request always lands as zero.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R2/R3: a write without a clear stores the data.
    assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && we) |=> (q == $past(wdata)));

    // R11: with no write and no clear, the contents hold.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !we) |=> $stable(q));

    // R1: leaving power-on reset finds the register cleared.
    assert_por_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));
endmodule

// File: rtl/gpiodir_oe_gate.sv
// Module: per-pin output-enable select.
// A pin in general-purpose mode drives when its direction bit is 1.
// A pin in any other mode passes the alternate function's enable through.
module gpiodir_oe_gate #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] gp_mode,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] alt_en,
    output logic [PINS-1:0] oe
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        // Purpose: choose between direction bit and alternate enable for pin i.
        always_comb begin
            if (gp_mode[i]) oe[i] = dir[i];
            else            oe[i] = alt_en[i];
        end

        // R9: a GPIO output pin is enabled, a GPIO input pin is not.
        assert_gpio_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
            gp_mode[i] |-> (oe[i] == dir[i]));

        // R10: outside GPIO mode the direction bit has no say.
        assert_alt_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !gp_mode[i] |-> (oe[i] == alt_en[i]));
    end
endmodule

// File: rtl/gpiodir_ctrl.sv
// Module: top of the port direction block.
// Holds two direction registers, decodes the register bus, merges the clear
// sources and drives the per-pin output-enables.
// Assumes the manual-reset and low-power-entry inputs must never reach the
// storage; they appear here only to be checked for having no effect.
module gpiodir_ctrl
    import gpiodir_pkg::*;
#(
    parameter int PINS = PIN_COUNT,
    localparam int HW  = PINS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dstby_enter,
    input  logic            mrst_n,
    input  logic            lp_enter,
    input  logic            bus_sel_hi,
    input  logic            bus_we,
    input  logic [HW-1:0]   bus_wdata,
    output logic [HW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_gpio,
    input  logic [PINS-1:0] alt_oe,
    output logic [PINS-1:0] pin_oe
);
    logic          clr_req;
    logic [1:0]    half_we;
    logic [HW-1:0] half_q [2];
    logic [PINS-1:0] dir_bits;

    // Purpose: merge the clearing reset classes into one request.
    always_comb clr_req = !rst_n || dstby_enter;

    // Purpose: steer the write strobe to the addressed half (0 = low, 1 = high).
    always_comb begin
        half_we[0] = bus_we && !bus_sel_hi;
        half_we[1] = bus_we &&  bus_sel_hi;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        gpiodir_half_reg #(.WIDTH(HW)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_req),
            .we    (half_we[h]),
            .wdata (bus_wdata),
            .q     (half_q[h])
        );
    end

    // Purpose: flatten the halves into a per-pin direction vector.
    always_comb dir_bits = {half_q[1], half_q[0]};

    // Purpose: combinational read of the selected half.
    always_comb bus_rdata = bus_sel_hi ? half_q[1] : half_q[0];

    gpiodir_oe_gate #(.PINS(PINS)) u_oe (
        .clk     (clk),
        .rst_n   (rst_n),
        .gp_mode (pin_gpio),
        .dir     (dir_bits),
        .alt_en  (alt_oe),
        .oe      (pin_oe)
    );

    // R7: a manual reset with no write and no clear leaves the direction bits alone.
    assert_mrst_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst_n && !bus_we && !dstby_enter) |=> $stable(dir_bits));

    // R8: low-power entry with no write and no clear leaves the direction bits alone.
    assert_lp_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_enter && !bus_we && !dstby_enter) |=> $stable(dir_bits));

    // R5: a write during deep-standby entry is overridden by the clear.
    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dstby_enter && bus_we) |=> (dir_bits == '0));
endmodule

// File: tb/tb_gpiodir_ctrl.sv
// Bench: scoreboard-style test of gpiodir_ctrl.
// Driver tasks act on falling edges and push expectations into a queue.
// The monitor pops and compares them 2 ns after each falling edge.
module tb_gpiodir_ctrl;
    localparam int PINS = 32;
    localparam int HW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dstby_enter = 1'b0;
    logic            mrst_n = 1'b1;
    logic            lp_enter = 1'b0;
    logic            bus_sel_hi = 1'b0;
    logic            bus_we = 1'b0;
    logic [HW-1:0]   bus_wdata = '0;
    logic [HW-1:0]   bus_rdata;
    logic [PINS-1:0] pin_gpio = '1;
    logic [PINS-1:0] alt_oe = '0;
    logic [PINS-1:0] pin_oe;

    typedef struct {
        bit          is_oe;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    gpiodir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dstby_enter(dstby_enter), .mrst_n(mrst_n),
        .lp_enter(lp_enter), .bus_sel_hi(bus_sel_hi), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_gpio(pin_gpio),
        .alt_oe(alt_oe), .pin_oe(pin_oe)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Monitor: compare queued expectations after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_oe ? pin_oe : {16'h0, bus_rdata};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic bus_write(input bit hi, input logic [15:0] d);
        @(negedge clk);
        bus_sel_hi = hi; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_rd(input bit hi, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_sel_hi = hi;
        sb_q.push_back('{is_oe: 1'b0, exp: {16'h0, e}, tag: tag});
    endtask

    task automatic check_oe(input logic [31:0] gp, input logic [31:0] alt,
                            input logic [31:0] e, input string tag);
        @(negedge clk);
        pin_gpio = gp; alt_oe = alt;
        sb_q.push_back('{is_oe: 1'b1, exp: e, tag: tag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_rd(1'b0, 16'h0000, "R1 low after power-on");
        check_rd(1'b1, 16'h0000, "R1 high after power-on");
        // R3 / R2 / R4
        bus_write(1'b0, 16'hA5C3);
        check_rd(1'b0, 16'hA5C3, "R3 low written");
        check_rd(1'b1, 16'h0000, "R3 high untouched");
        bus_write(1'b1, 16'h1234);
        check_rd(1'b1, 16'h1234, "R2 high written");
        check_rd(1'b0, 16'hA5C3, "R4 low selected again");
        // R9 / R10: output-enable gating
        check_oe(32'hFFFF_FFFF, 32'h0, 32'h1234_A5C3, "R9 all pins gpio");
        check_oe(32'hFFFF_0000, 32'hFFFF_FFFF, 32'h1234_FFFF, "R10 mixed select");
        check_oe(32'h0000_0000, 32'h0F0F_0F0F, 32'h0F0F_0F0F, "R10 all alternate");
        check_oe(32'h00FF_FF00, 32'hF0F0_F0F0, 32'hF034_A5F0, "R9 R10 interleaved");
        // R11: reads independent of function select
        check_rd(1'b1, 16'h1234, "R11 high with alt mode");
        // R7: manual reset pulse
        @(negedge clk); mrst_n = 1'b0;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        check_rd(1'b1, 16'h1234, "R7 high after manual reset");
        check_rd(1'b0, 16'hA5C3, "R7 low after manual reset");
        // R8: low-power entry pulse
        @(negedge clk); lp_enter = 1'b1;
        @(negedge clk); lp_enter = 1'b0;
        check_rd(1'b1, 16'h1234, "R8 high after low-power entry");
        check_rd(1'b0, 16'hA5C3, "R8 low after low-power entry");
        // R6: deep standby clear
        @(negedge clk); dstby_enter = 1'b1;
        @(negedge clk); dstby_enter = 1'b0;
        check_rd(1'b1, 16'h0000, "R6 high after deep standby");
        check_rd(1'b0, 16'h0000, "R6 low after deep standby");
        check_oe(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R9 all inputs after clear");
        // R5: clear wins over a same-cycle write
        @(negedge clk);
        bus_sel_hi = 1'b1; bus_we = 1'b1; bus_wdata = 16'hBEEF; dstby_enter = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; dstby_enter = 1'b0;
        check_rd(1'b1, 16'h0000, "R5 deep standby beats write");
        bus_write(1'b0, 16'h5A5A);
        @(negedge clk);
        bus_sel_hi = 1'b0; bus_we = 1'b1; bus_wdata = 16'hFFFF; rst_n = 1'b0;
        @(negedge clk);
        bus_we = 1'b0; rst_n = 1'b1;
        check_rd(1'b0, 16'h0000, "R5 R1 power-on beats write");
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule